// File: doc/BRIEF.md
# Native Trigger Privilege Gate

This block decides, for one native hardware trigger, whether a trigger that raises a breakpoint exception may match or fire in the hart's current privilege state. It exists so that a breakpoint trigger cannot fire again inside its own exception handler. A trigger whose action is anything other than a breakpoint exception, such as entry to debug mode, always passes the gate.

Which of two exclusive anti-reentrancy schemes is built is chosen by the `HAS_SMODE` parameter. When supervisor mode is built, the gate uses the interrupt-enable bits together with the breakpoint delegation bits. When supervisor mode is absent, the block holds a small trigger-control register. That register has a machine trigger-enable bit and a previous-enable bit. A trap into machine mode saves the enable bit and clears it, and an mret restores it. The block also has a second output, the privilege-level enable, which the trigger's match logic uses.

Top module: `trig_priv_gate`

## Requirements
- R1: When `actionCode` is nonzero, `actionAllowed` and `modeEnabled` are both 1, whatever the privilege, status and delegation inputs are.
- R2: With S-mode built (`HAS_SMODE`=1), `privMode` 3 is machine mode. In that mode an action-0 trigger is allowed exactly when `mstatusMie` is 1.
- R3: With S-mode built, `privMode` 1 with `virtMode` 0 is S-mode. There an action-0 trigger is blocked exactly when `medelegBp` is 1 and `sstatusSie` is 0. In user mode (`privMode` 0) it is always allowed.
- R4: With S-mode built, `privMode` 1 with `virtMode` 1 is VS-mode. There an action-0 trigger is blocked exactly when `medelegBp` and `hedelegBp` are both 1 and `vsstatusSie` is 0.
- R5: With S-mode built, `csrRdData` is always 0 and writes have no effect. In machine mode an action-0 trigger then has `modeEnabled` 0.
- R6: With S-mode absent, the control register has the enable bit at bit 3 and the previous-enable bit at bit 7. Both reset to 0. A `csrWrEn` pulse loads both from `csrWrData` at the next edge. All other bits read 0.
- R7: With S-mode absent, an action-0 trigger in machine mode is allowed exactly when the enable bit is 1. Below machine mode it is always allowed, and the delegation and SIE inputs are ignored.
- R8: With S-mode absent, a `trapEntry` pulse copies the enable bit into the previous-enable bit and clears the enable bit.
- R9: With S-mode absent, an `mretEvent` pulse sets both bits to 1 if the previous-enable bit is 1, and otherwise sets both to 0.
- R10: If `trapEntry` and `mretEvent` are asserted in the same cycle, trap entry wins. Either event overrides a CSR write in the same cycle.
- R11: `modeEnabled` is 1 when `privMode` is below 3, or the action is nonzero, or the enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| privMode | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virtMode | input | 1 | Virtualization active |
| actionCode | input | ACT_W | Trigger action; 0 means breakpoint exception |
| mstatusMie | input | 1 | Machine interrupt enable |
| sstatusSie | input | 1 | Supervisor interrupt enable |
| vsstatusSie | input | 1 | Virtual-supervisor interrupt enable |
| medelegBp | input | 1 | Breakpoint delegated from M to S |
| hedelegBp | input | 1 | Breakpoint delegated from HS to VS |
| trapEntry | input | 1 | Trap into machine mode this cycle |
| mretEvent | input | 1 | mret retires this cycle |
| csrWrEn | input | 1 | Write strobe for the trigger-control register |
| csrWrData | input | XLEN | Write data |
| csrRdData | output | XLEN | Trigger-control register read value |
| actionAllowed | output | 1 | Trigger may match or fire under the re-entrancy rule |
| modeEnabled | output | 1 | Privilege-level enable for matching |

## Verification
If the enable or previous-enable bit held a wrong value, it would show on `csrRdData` in the very next sample. It would also flip `actionAllowed` and `modeEnabled` at once whenever an action-0 trigger is evaluated in machine mode. A slip in event priority shows one cycle after the colliding strobes, because the register then holds the saved pattern instead of the restored or written one. A wrong gating term in the S-mode variant shows combinationally in the same cycle as the input pattern that reaches it. Both variants are therefore compared against the reference on every clock, under mixed random events.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;

  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_RSVD  = 2'd2,
    PRV_MACH  = 2'd3
  } privT;

  // Update strobes from control to the register datapath (at most one set)
  typedef struct packed {
    logic saveOnTrap;
    logic restoreOnRet;
    logic loadFromCsr;
  } tctlStrobeT;

  localparam int MTE_POS  = 3;
  localparam int MPTE_POS = 7;

endpackage

// File: rtl/trig_gate_ctrl.sv
module trig_gate_ctrl
  import trig_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b0,
  parameter int ACT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  privT             privMode,
  input  logic             virtMode,
  input  logic [ACT_W-1:0] actionCode,
  input  logic             mstatusMie,
  input  logic             sstatusSie,
  input  logic             vsstatusSie,
  input  logic             medelegBp,
  input  logic             hedelegBp,
  input  logic             trapEntry,
  input  logic             mretEvent,
  input  logic             csrWrEn,
  input  logic             mteBit,
  output tctlStrobeT       strobes,
  output logic             actionAllowed,
  output logic             modeEnabled
);

  logic bpAction;
  logic inMach;
  logic inSuper;
  logic gateOk;

  assign bpAction = (actionCode == '0);
  assign inMach   = (privMode == PRV_MACH);
  assign inSuper  = (privMode == PRV_SUPER);

  // Event priority: trap entry, then mret, then software write
  always_comb begin
    strobes = '0;
    if (trapEntry)      strobes.saveOnTrap   = 1'b1;
    else if (mretEvent) strobes.restoreOnRet = 1'b1;
    else if (csrWrEn)   strobes.loadFromCsr  = 1'b1;
  end

  generate
    if (HAS_SMODE) begin : gSupGate
      logic unusedGate;
      assign unusedGate = mteBit;
      assign gateOk =
        (!inMach  || mstatusMie) &&
        (!inSuper || virtMode  || !medelegBp || sstatusSie) &&
        (!inSuper || !virtMode || !medelegBp || !hedelegBp || vsstatusSie);

      // R2
      mach_mie_block_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inMach && bpAction && !mstatusMie) |-> !actionAllowed);
      // R4
      vs_block_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inSuper && virtMode && bpAction && medelegBp && hedelegBp && !vsstatusSie)
          |-> !actionAllowed);
    end else begin : gTctlGate
      logic unusedGate;
      assign unusedGate = ^{mstatusMie, sstatusSie, vsstatusSie, medelegBp,
                            hedelegBp, virtMode};
      assign gateOk = !inMach || mteBit;

      // R7
      mach_needs_mte_chk: assert property (@(posedge clk) disable iff (!rstN)
        (inMach && bpAction && actionAllowed) |-> mteBit);
    end
  endgenerate

  assign actionAllowed = !bpAction || gateOk;
  assign modeEnabled   = !inMach || !bpAction || mteBit;

  // R1
  nonzero_action_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bpAction |-> (actionAllowed && modeEnabled));

  // R11
  below_mach_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inMach |-> modeEnabled);

endmodule

// File: rtl/trig_gate_dp.sv
module trig_gate_dp
  import trig_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b0,
  parameter int XLEN      = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  tctlStrobeT      strobes,
  input  logic [XLEN-1:0] csrWrData,
  output logic [XLEN-1:0] csrRdData,
  output logic            mteBit
);

  generate
    if (!HAS_SMODE) begin : gTctlReg
      logic mteQ;
      logic mpteQ;
      logic unusedWr;
      assign unusedWr = ^csrWrData;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          mteQ  <= 1'b0;
          mpteQ <= 1'b0;
        end else if (strobes.saveOnTrap) begin
          mpteQ <= mteQ;
          mteQ  <= 1'b0;
        end else if (strobes.restoreOnRet) begin
          mteQ  <= mpteQ;
        end else if (strobes.loadFromCsr) begin
          mteQ  <= csrWrData[MTE_POS];
          mpteQ <= csrWrData[MPTE_POS];
        end
      end

      always_comb begin
        csrRdData           = '0;
        csrRdData[MTE_POS]  = mteQ;
        csrRdData[MPTE_POS] = mpteQ;
      end
      assign mteBit = mteQ;

      // R8
      trap_save_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.saveOnTrap |=> (!mteQ && (mpteQ == $past(mteQ))));
      // R9
      mret_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.restoreOnRet |=> ((mteQ == $past(mpteQ)) && (mpteQ == $past(mpteQ))));
      // R6
      csr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.loadFromCsr |=> ((mteQ == $past(csrWrData[MTE_POS])) &&
                                 (mpteQ == $past(csrWrData[MPTE_POS]))));
      // R10
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobes == '0) |=> $stable({mteQ, mpteQ}));
    end else begin : gNoReg
      logic unusedWr;
      assign unusedWr  = ^{strobes, csrWrData, clk, rstN};
      assign csrRdData = '0;
      assign mteBit    = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/trig_priv_gate.sv
module trig_priv_gate
  import trig_gate_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b0,
  parameter int ACT_W     = 4,
  parameter int XLEN      = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       privMode,
  input  logic             virtMode,
  input  logic [ACT_W-1:0] actionCode,
  input  logic             mstatusMie,
  input  logic             sstatusSie,
  input  logic             vsstatusSie,
  input  logic             medelegBp,
  input  logic             hedelegBp,
  input  logic             trapEntry,
  input  logic             mretEvent,
  input  logic             csrWrEn,
  input  logic [XLEN-1:0]  csrWrData,
  output logic [XLEN-1:0]  csrRdData,
  output logic             actionAllowed,
  output logic             modeEnabled
);

  tctlStrobeT strobeBus;
  logic       mteBit;

  trig_gate_ctrl #(.HAS_SMODE(HAS_SMODE), .ACT_W(ACT_W)) ctrlU (
    .clk(clk), .rstN(rstN), .privMode(privT'(privMode)), .virtMode(virtMode),
    .actionCode(actionCode), .mstatusMie(mstatusMie), .sstatusSie(sstatusSie),
    .vsstatusSie(vsstatusSie), .medelegBp(medelegBp), .hedelegBp(hedelegBp),
    .trapEntry(trapEntry), .mretEvent(mretEvent), .csrWrEn(csrWrEn),
    .mteBit(mteBit), .strobes(strobeBus), .actionAllowed(actionAllowed),
    .modeEnabled(modeEnabled)
  );

  trig_gate_dp #(.HAS_SMODE(HAS_SMODE), .XLEN(XLEN)) dpU (
    .clk(clk), .rstN(rstN), .strobes(strobeBus), .csrWrData(csrWrData),
    .csrRdData(csrRdData), .mteBit(mteBit)
  );

endmodule

// File: tb/trig_priv_gate_test.sv
`timescale 1ns/1ps
module trig_priv_gate_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  privMode = 2'd3;
  logic        virtMode = 1'b0;
  logic [3:0]  actionCode = 4'd0;
  logic        mstatusMie = 1'b0, sstatusSie = 1'b0, vsstatusSie = 1'b0;
  logic        medelegBp = 1'b0, hedelegBp = 1'b0;
  logic        trapEntry = 1'b0, mretEvent = 1'b0, csrWrEn = 1'b0;
  logic [31:0] csrWrData = '0;
  logic [31:0] rdT, rdS;
  logic        allowT, allowS, modeT, modeS;

  int checks = 0;
  int errors = 0;
  int mteM = 0, mpteM = 0;
  string csrReq = "R6";
  bit done = 0;

  always #5 clk = ~clk;

  trig_priv_gate #(.HAS_SMODE(1'b0)) uut (
    .clk(clk), .rstN(rstN), .privMode(privMode), .virtMode(virtMode),
    .actionCode(actionCode), .mstatusMie(mstatusMie), .sstatusSie(sstatusSie),
    .vsstatusSie(vsstatusSie), .medelegBp(medelegBp), .hedelegBp(hedelegBp),
    .trapEntry(trapEntry), .mretEvent(mretEvent), .csrWrEn(csrWrEn),
    .csrWrData(csrWrData), .csrRdData(rdT), .actionAllowed(allowT),
    .modeEnabled(modeT));

  trig_priv_gate #(.HAS_SMODE(1'b1)) uutS (
    .clk(clk), .rstN(rstN), .privMode(privMode), .virtMode(virtMode),
    .actionCode(actionCode), .mstatusMie(mstatusMie), .sstatusSie(sstatusSie),
    .vsstatusSie(vsstatusSie), .medelegBp(medelegBp), .hedelegBp(hedelegBp),
    .trapEntry(trapEntry), .mretEvent(mretEvent), .csrWrEn(csrWrEn),
    .csrWrData(csrWrData), .csrRdData(rdS), .actionAllowed(allowS),
    .modeEnabled(modeS));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit refAllow(input bit hasS, input int mte);
    int pv = int'(privMode);
    if (actionCode != 0) return 1'b1;
    if (hasS) begin
      if (pv == 3) return mstatusMie;
      if (pv == 1 && !virtMode) return !(medelegBp && !sstatusSie);
      if (pv == 1 && virtMode) return !(medelegBp && hedelegBp && !vsstatusSie);
      return 1'b1;
    end
    return (pv != 3) || (mte != 0);
  endfunction

  function automatic string allowReq(input bit hasS);
    if (actionCode != 0) return "R1";
    if (!hasS) return "R7";
    if (privMode == 2'd3) return "R2";
    if (privMode == 2'd1 && virtMode) return "R4";
    return "R3";
  endfunction

  // Reference register update at the clock edge
  task automatic modelEdge();
    if (!rstN) begin
      mteM = 0; mpteM = 0; csrReq = "R6";
    end else if (trapEntry) begin
      csrReq = (mretEvent || csrWrEn) ? "R10" : "R8";
      mpteM = mteM; mteM = 0;
    end else if (mretEvent) begin
      csrReq = csrWrEn ? "R10" : "R9";
      mteM = mpteM;
    end else if (csrWrEn) begin
      csrReq = "R6";
      mteM = csrWrData[3]; mpteM = csrWrData[7];
    end
  endtask

  task automatic compareAll();
    logic [31:0] expRd;
    bit expMode;
    expRd = (32'(mpteM) << 7) | (32'(mteM) << 3);
    chk(rdT == expRd, csrReq, "tcontrol read", rdT, expRd);
    chk(rdS == 32'd0, "R5", "absent register read", rdS, 0);
    chk(allowT == refAllow(1'b0, mteM), allowReq(1'b0), "allow no-S", allowT, refAllow(1'b0, mteM));
    chk(allowS == refAllow(1'b1, 0), allowReq(1'b1), "allow with-S", allowS, refAllow(1'b1, 0));
    expMode = (privMode != 2'd3) || (actionCode != 0) || (mteM != 0);
    chk(modeT == expMode, (actionCode != 0) ? "R1" : "R11", "mode enable no-S", modeT, expMode);
    expMode = (privMode != 2'd3) || (actionCode != 0);
    chk(modeS == expMode, (actionCode != 0) ? "R1" : "R5", "mode enable with-S", modeS, expMode);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic setEv(input bit tr, input bit mr, input bit wr, input logic [31:0] d);
    trapEntry = tr; mretEvent = mr; csrWrEn = wr; csrWrData = d;
  endtask

  initial begin
    repeat (3) cyc();
    // R6 reset state
    chk(rdT == 32'd0, "R6", "reset read", rdT, 0);
    @(negedge clk); rstN = 1'b1;
    privMode = 2'd3; actionCode = 4'd0;
    // R6: write all ones, only bits 3 and 7 stick
    setEv(0, 0, 1, 32'hFFFF_FFFF); cyc();
    setEv(0, 0, 0, 32'h0); cyc();
    chk(rdT == 32'h88, "R6", "masked write", rdT, 32'h88);
    // R8: trap saves and clears
    setEv(1, 0, 0, 32'h0); cyc();
    chk(rdT == 32'h80, "R8", "trap save", rdT, 32'h80);
    chk(allowT == 1'b0, "R7", "blocked in M after trap", allowT, 0);
    // R9: mret restores both
    setEv(0, 1, 0, 32'h0); cyc();
    chk(rdT == 32'h88, "R9", "mret restore", rdT, 32'h88);
    // R10: trap beats mret, event beats write
    setEv(1, 1, 1, 32'h0); cyc();
    chk(rdT == 32'h80, "R10", "trap over mret", rdT, 32'h80);
    setEv(0, 1, 1, 32'h0); cyc();
    chk(rdT == 32'h88, "R10", "mret over write", rdT, 32'h88);
    setEv(1, 0, 0, 32'h0); cyc();
    setEv(1, 0, 0, 32'h0); cyc();
    setEv(0, 1, 0, 32'h0); cyc();
    chk(rdT == 32'h00, "R9", "mret with mpte clear", rdT, 0);
    setEv(0, 0, 0, 32'h0); cyc();

    // Mixed random stimulus, compared every clock
    for (int i = 0; i < 4000; i++) begin
      privMode    = 2'($urandom);
      virtMode    = 1'($urandom);
      actionCode  = ($urandom % 2) ? 4'd0 : 4'($urandom);
      mstatusMie  = 1'($urandom);
      sstatusSie  = 1'($urandom);
      vsstatusSie = 1'($urandom);
      medelegBp   = 1'($urandom);
      hedelegBp   = 1'($urandom);
      setEv(($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0, $urandom);
      cyc();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_800_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule